// File: doc/BRIEF.md
# Token-Tagged Direct-Mapped Data Cache

This block is a small direct-mapped data cache that guards against stray memory accesses by recognising a secret line-sized marker value. A 512-bit token is kept in a private register that the core can load but never read back. Every line the cache fetches from memory is compared with that token as it arrives. When they match, a single per-line "armed" bit is set. Cache hits never compare data. They only consult that bit, so the full-width comparator sits only on the memory side of the cache.

Software places tokens around buffers or over freed regions. An ordinary load or store that lands on an armed line is refused and reported as an error, together with the faulting address. Two line-wide commands manage the markers. Arming writes the token over a whole aligned line and sets its bit. Disarming clears the bit and zeroes the line. On eviction, an armed line is written back as the token value, whatever the data array holds. A dirty unarmed line is written back with its array data. A clean line is dropped.

The controller is a five-state machine:
- ST_IDLE: accepts a request (transition *accept* to ST_LOOKUP).
- ST_LOOKUP: either answers the request (*respond* back to ST_IDLE), or goes to ST_EVICT (*spill*, when the victim is dirty or armed), or goes to ST_FETCH (*miss*, for a load or store).
- ST_EVICT: waits for the memory handshake, invalidates the victim and returns to ST_LOOKUP (*spilled*).
- ST_FETCH: issues the line read and moves to ST_FILL (*issued*).
- ST_FILL: installs the returned line and its comparison result, then returns to ST_LOOKUP (*filled*).

Top module: `tok_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: Each accepted request produces exactly one single-cycle response. A store to an unarmed line updates only the 64-bit word selected by address bits [5:3], and a later load of that word returns the stored value.
- R3: A load that misses reads the 512-bit line from memory at the request address with bits [5:0] cleared. The load then returns bits [64*w+63:64*w] of that line, where w = address bits [5:3].
- R4: A line fetched from memory is armed exactly when all 512 bits equal the token. A line that differs from the token in a single bit is not armed.
- R5: A load or store (req_op 0 or 1) that hits an armed line answers with rsp_err=1, rsp_err_addr equal to the request address and rsp_rdata=0. The store leaves the line unchanged: the token is still what is written back on eviction. Responses without an error carry rsp_err_addr=0.
- R6: An arm command (req_op 2) makes the line armed. Later loads report errors, and an eviction writes the token value to memory.
- R7: A disarm command (req_op 3) clears the armed state and zeroes the line. Loads then return 0 without error, and an eviction writes zeros to memory.
- R8: Eviction of a dirty unarmed line writes its array data. A clean unarmed line is replaced with no memory write.
- R9: An arm or disarm that misses allocates the line without issuing any memory read.
- R10: A memory request holds mem_req_valid, address and write flag steady until mem_req_ready. After each memory operation the memory contents agree with the cached view.
- R11: Pulsing tok_wr_en loads tok_wr_data as the token used by later fills and arm commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_wr_en | input | 1 | Load the token register |
| tok_wr_data | input | LINE_W | New token value |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | 0 load, 1 store, 2 arm, 3 disarm |
| req_addr | input | ADDR_W | Byte address, 8-byte aligned |
| req_wdata | input | WORD_W | Store data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | WORD_W | Load data (0 otherwise) |
| rsp_err | output | 1 | Access hit an armed line |
| rsp_err_addr | output | ADDR_W | Faulting address when rsp_err is set |
| mem_req_valid | output | 1 | Memory line request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 write-back, 0 line read |
| mem_req_addr | output | ADDR_W | Line-aligned memory address |
| mem_req_wdata | output | LINE_W | Write-back line |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | LINE_W | Returned line |

## Verification
The bench builds the cache with its defaults: eight 512-bit lines, a 64-bit word port and 64-bit comparator chunks. Random traffic is confined to sixteen line addresses, so each index is shared by two tags. This keeps spills of armed, dirty and clean victims frequent. Memory readiness and read latency vary at random, which exercises held requests and back-to-back spill-then-fetch sequences. Directed cases plant the token and a one-bit-different copy in memory. A final sweep forces every cached line out and compares memory with the bench's own view of line contents.

// File: rtl/tok_cache_pkg.sv
package tok_cache_pkg;

    // Core command encoding, fixed by the request port definition
    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_ARM    = 2'd2,
        OP_DISARM = 2'd3
    } tc_op_e;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_EVICT  = 3'd2,
        ST_FETCH  = 3'd3,
        ST_FILL   = 3'd4
    } tc_state_e;

endpackage

// File: rtl/tc_token_unit.sv
module tc_token_unit #(
    parameter int LINE_W  = 512,
    parameter int CHUNK_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [LINE_W-1:0] load_val,
    input  logic [LINE_W-1:0] cmp_line,
    output logic [LINE_W-1:0] token,
    output logic              match
);

    localparam int NCHUNK = LINE_W / CHUNK_W;

    logic [LINE_W-1:0] token_q;
    logic [NCHUNK-1:0] chunk_eq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            token_q <= '0;
        end else if (load_en) begin
            token_q <= load_val;
        end
    end

    // Slice-wise equality followed by a reduction keeps each compare narrow
    for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
        assign chunk_eq[g] = (cmp_line[g*CHUNK_W +: CHUNK_W] == token_q[g*CHUNK_W +: CHUNK_W]);
    end

    assign match = &chunk_eq;
    assign token = token_q;

endmodule

// File: rtl/tc_arm_bits.sv
module tc_arm_bits #(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_armed
);

    logic [NUM_LINES-1:0] arm_q;
    logic [NUM_LINES-1:0] sel;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_sel
        assign sel[i] = (wr_idx == IDX_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (sel[i] && set_en) begin
                    arm_q[i] <= 1'b1;
                end else if (sel[i] && clr_en) begin
                    arm_q[i] <= 1'b0;
                end
            end
        end
    end

    assign rd_armed = arm_q[rd_idx];

endmodule

// File: rtl/tc_line_store.sv
module tc_line_store #(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 23,
    parameter int LINE_W    = 512,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line
);

    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;
    logic [TAG_W-1:0]     tag_q  [NUM_LINES];
    logic [LINE_W-1:0]    line_q [NUM_LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            line_q[wr_idx] <= wr_line;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = line_q[rd_idx];

endmodule

// File: rtl/tok_cache.sv
module tok_cache
    import tok_cache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_W      = 512,
    parameter int WORD_W      = 64,
    parameter int NUM_LINES   = 8,
    parameter int CMP_CHUNK_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_wr_en,
    input  logic [LINE_W-1:0] tok_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] rsp_err_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_rdata
);

    localparam int OFF_W  = $clog2(LINE_W / 8);
    localparam int WB_W   = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(LINE_W / WORD_W);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    // ---------------- registered request ----------------
    tc_state_e         st_q, st_d;
    tc_op_e            q_op;
    logic [ADDR_W-1:0] q_addr;
    logic [WORD_W-1:0] q_wdata;

    logic [IDX_W-1:0]  q_idx;
    logic [TAG_W-1:0]  q_tag;
    logic [WSEL_W-1:0] q_word;

    assign q_idx  = q_addr[OFF_W +: IDX_W];
    assign q_tag  = q_addr[ADDR_W-1 -: TAG_W];
    assign q_word = q_addr[WB_W +: WSEL_W];

    // ---------------- storage and token ----------------
    logic              rd_valid, rd_dirty, rd_armed;
    logic [TAG_W-1:0]  rd_tag;
    logic [LINE_W-1:0] rd_line;
    logic              wr_en, wr_valid, wr_dirty;
    logic [TAG_W-1:0]  wr_tag;
    logic [LINE_W-1:0] wr_line;
    logic              arm_set, arm_clr;
    logic [LINE_W-1:0] token;
    logic              fill_match;

    tc_token_unit #(
        .LINE_W  (LINE_W),
        .CHUNK_W (CMP_CHUNK_W)
    ) u_token (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (tok_wr_en),
        .load_val (tok_wr_data),
        .cmp_line (mem_rsp_rdata),
        .token    (token),
        .match    (fill_match)
    );

    tc_arm_bits #(
        .NUM_LINES (NUM_LINES)
    ) u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (arm_set),
        .clr_en   (arm_clr),
        .wr_idx   (q_idx),
        .rd_idx   (q_idx),
        .rd_armed (rd_armed)
    );

    tc_line_store #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W),
        .LINE_W    (LINE_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (q_idx),
        .wr_en    (wr_en),
        .wr_idx   (q_idx),
        .wr_valid (wr_valid),
        .wr_dirty (wr_dirty),
        .wr_tag   (wr_tag),
        .wr_line  (wr_line),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .rd_line  (rd_line)
    );

    // ---------------- lookup helpers ----------------
    logic              hit, victim_busy, line_cmd;
    logic [WORD_W-1:0] rd_word;
    logic [LINE_W-1:0] merged_line;

    assign hit         = rd_valid && (rd_tag == q_tag);
    assign victim_busy = rd_valid && !hit && (rd_dirty || rd_armed);
    assign line_cmd    = (q_op == OP_ARM) || (q_op == OP_DISARM);
    assign rd_word     = rd_line[q_word*WORD_W +: WORD_W];

    always_comb begin
        merged_line = rd_line;
        merged_line[q_word*WORD_W +: WORD_W] = q_wdata;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- next state and array control ----------------
    logic              rsp_fire, rsp_err_d;
    logic [WORD_W-1:0] rsp_data_d;

    always_comb begin
        st_d       = st_q;
        wr_en      = 1'b0;
        wr_valid   = 1'b1;
        wr_dirty   = 1'b0;
        wr_tag     = q_tag;
        wr_line    = rd_line;
        arm_set    = 1'b0;
        arm_clr    = 1'b0;
        rsp_fire   = 1'b0;
        rsp_err_d  = 1'b0;
        rsp_data_d = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d = ST_LOOKUP;                    // accept
                end
            end
            ST_LOOKUP: begin
                if (hit || (line_cmd && !victim_busy)) begin
                    st_d     = ST_IDLE;                  // respond
                    rsp_fire = 1'b1;
                    unique case (q_op)
                        OP_LOAD: begin
                            rsp_err_d  = rd_armed;
                            rsp_data_d = rd_armed ? '0 : rd_word;
                        end
                        OP_STORE: begin
                            if (rd_armed) begin
                                rsp_err_d = 1'b1;
                            end else begin
                                wr_en    = 1'b1;
                                wr_dirty = 1'b1;
                                wr_line  = merged_line;
                            end
                        end
                        OP_ARM: begin
                            wr_en    = 1'b1;
                            wr_dirty = 1'b1;
                            wr_line  = token;
                            arm_set  = 1'b1;
                        end
                        OP_DISARM: begin
                            wr_en    = 1'b1;
                            wr_dirty = 1'b1;
                            wr_line  = '0;
                            arm_clr  = 1'b1;
                        end
                    endcase
                end else if (victim_busy) begin
                    st_d = ST_EVICT;                     // spill
                end else begin
                    st_d = ST_FETCH;                     // miss
                end
            end
            ST_EVICT: begin
                if (mem_req_ready) begin
                    st_d     = ST_LOOKUP;                // spilled
                    wr_en    = 1'b1;
                    wr_valid = 1'b0;
                    wr_tag   = rd_tag;
                    arm_clr  = 1'b1;
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) begin
                    st_d = ST_FILL;                      // issued
                end
            end
            ST_FILL: begin
                if (mem_rsp_valid) begin
                    st_d    = ST_LOOKUP;                 // filled
                    wr_en   = 1'b1;
                    wr_line = mem_rsp_rdata;
                    arm_set = fill_match;
                    arm_clr = !fill_match;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_op         <= OP_LOAD;
            q_addr       <= '0;
            q_wdata      <= '0;
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
            rsp_err      <= 1'b0;
            rsp_err_addr <= '0;
        end else begin
            if (st_q == ST_IDLE && req_valid) begin
                q_op    <= tc_op_e'(req_op);
                q_addr  <= req_addr;
                q_wdata <= req_wdata;
            end
            rsp_valid    <= rsp_fire;
            rsp_rdata    <= rsp_data_d;
            rsp_err      <= rsp_err_d;
            rsp_err_addr <= rsp_err_d ? q_addr : '0;
        end
    end

    assign req_ready     = (st_q == ST_IDLE);
    assign mem_req_valid = (st_q == ST_EVICT) || (st_q == ST_FETCH);
    assign mem_req_we    = (st_q == ST_EVICT);
    assign mem_req_addr  = (st_q == ST_EVICT) ? {rd_tag, q_idx, {OFF_W{1'b0}}}
                                              : {q_tag,  q_idx, {OFF_W{1'b0}}};
    assign mem_req_wdata = rd_armed ? token : rd_line;

endmodule

// File: rtl/tok_cache_chk.sv
module tok_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [WORD_W-1:0] rsp_rdata,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5
    err_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

endmodule

bind tok_cache tok_cache_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .rsp_rdata     (rsp_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/tok_cache_bench.sv
module tok_cache_bench;

    localparam int ADDR_W = 32;
    localparam int LINE_W = 512;
    localparam int WORD_W = 64;
    localparam int MLINES = 64;

    localparam logic [1:0] C_LOAD = 2'd0, C_STORE = 2'd1, C_ARM = 2'd2, C_DISARM = 2'd3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tok_wr_en = 1'b0;
    logic [LINE_W-1:0] tok_wr_data = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WORD_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [WORD_W-1:0] rsp_rdata;
    logic              rsp_err;
    logic [ADDR_W-1:0] rsp_err_addr;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic              mem_req_we;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [LINE_W-1:0] mem_req_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [LINE_W-1:0] mem_rsp_rdata = '0;

    always #4 clk = ~clk;   // 8 ns period

    tok_cache u_tok_cache (
        .clk(clk), .rst_n(rst_n), .tok_wr_en(tok_wr_en), .tok_wr_data(tok_wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .rsp_err_addr(rsp_err_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [LINE_W-1:0] mem_model [MLINES];
    logic [LINE_W-1:0] g_data    [MLINES];
    bit                g_armed   [MLINES];
    logic [LINE_W-1:0] tok;

    int                wr_count = 0;
    int                rd_count = 0;
    int                last_wr_line = -1;
    logic [LINE_W-1:0] last_wr_data = '0;
    bit                rd_wait = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [LINE_W-1:0] rand_line();
        logic [LINE_W-1:0] v;
        for (int k = 0; k < LINE_W / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] rand_word();
        return {$urandom, $urandom};
    endfunction

    // Memory responder: random readiness and read latency
    initial begin
        bit                hs_pend = 1'b0;
        bit                hs_we = 1'b0;
        int                hs_line = 0;
        logic [LINE_W-1:0] hs_data = '0;
        int                rd_delay = 0;
        int                rd_line = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (hs_pend) begin
                hs_pend = 1'b0;
                if (hs_we) begin
                    mem_model[hs_line] = hs_data;
                    wr_count++;
                    last_wr_line = hs_line;
                    last_wr_data = hs_data;
                end else begin
                    rd_count++;
                    rd_line  = hs_line;
                    rd_delay = $urandom % 3;
                    rd_wait  = 1'b1;
                end
            end
            if (rd_wait) begin
                if (rd_delay == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = mem_model[rd_line];
                    rd_wait = 1'b0;
                end else begin
                    rd_delay--;
                end
            end
            mem_req_ready = ($urandom % 4) != 0;
            if (mem_req_valid && mem_req_ready) begin
                hs_pend = 1'b1;
                hs_we   = mem_req_we;
                hs_line = int'(mem_req_addr[11:6]);
                hs_data = mem_req_wdata;
            end
        end
    end

    // One core request against the bench's own view of line contents
    task automatic do_op(input logic [1:0] op, input int line, input int word,
                         input logic [WORD_W-1:0] wd, input string req);
        logic [ADDR_W-1:0] addr;
        bit                exp_err;
        logic [WORD_W-1:0] exp_data;
        addr = ADDR_W'(line * 64 + word * 8);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        exp_err  = 1'b0;
        exp_data = '0;
        case (op)
            C_LOAD: begin
                exp_err  = g_armed[line];
                exp_data = exp_err ? '0 : g_data[line][word*64 +: 64];
            end
            C_STORE: begin
                exp_err = g_armed[line];
                if (!exp_err) g_data[line][word*64 +: 64] = wd;
            end
            C_ARM: begin
                g_data[line] = tok; g_armed[line] = 1'b1;
            end
            default: begin
                g_data[line] = '0; g_armed[line] = 1'b0;
            end
        endcase
        chk(rsp_err == exp_err, {req, " err flag"}, 64'(rsp_err), 64'(exp_err));
        chk(rsp_rdata == exp_data, {req, " read data"}, rsp_rdata, exp_data);
        chk(rsp_err_addr == (exp_err ? addr : '0), {req, " R5 fault address"},
            64'(rsp_err_addr), 64'(exp_err ? addr : '0));
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int wc, rc, r, ln;
        void'($urandom(32'd20241));
        tok = rand_line();
        for (int i = 0; i < MLINES; i++) mem_model[i] = rand_line();
        mem_model[20] = tok;
        mem_model[21] = tok ^ (LINE_W'(1) << 77);
        for (int i = 0; i < MLINES; i++) begin
            g_data[i]  = mem_model[i];
            g_armed[i] = (mem_model[i] == tok);
        end

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1 no response in reset", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0,
            "R1 idle outputs", {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'd4);

        // R11 token load
        tok_wr_en = 1'b1; tok_wr_data = tok;
        @(negedge clk);
        tok_wr_en = 1'b0;

        // R4 exact and near-miss token lines; R3 refill data
        do_op(C_LOAD, 20, 2, '0, "R4 R11 token line fetched");
        do_op(C_LOAD, 21, 5, '0, "R4 R3 one-bit-different line");
        // R5 store to armed line is refused
        do_op(C_STORE, 20, 1, 64'hDEAD_BEEF_0000_1111, "R5 store to armed");
        wc = wr_count;
        do_op(C_LOAD, 28, 0, '0, "R3 conflict load");
        chk(wr_count == wc + 1 && last_wr_line == 20, "R5 armed line written back",
            64'(last_wr_line), 64'd20);
        chk(last_wr_data == tok, "R5 refused store left token", last_wr_data[63:0], tok[63:0]);

        // R9 arm miss allocates without a read; R6 armed behaviour
        rc = rd_count;
        do_op(C_ARM, 30, 0, '0, "R6 arm");
        chk(rd_count == rc, "R9 arm miss issues no read", 64'(rd_count), 64'(rc));
        do_op(C_LOAD, 30, 3, '0, "R6 load of armed line");
        do_op(C_LOAD, 38, 3, '0, "R3 evicting load");
        chk(last_wr_line == 30 && last_wr_data == tok, "R6 eviction writes token",
            last_wr_data[63:0], tok[63:0]);

        // R7 disarm
        rc = rd_count;
        do_op(C_DISARM, 30, 0, '0, "R7 disarm");
        chk(rd_count == rc, "R9 disarm miss issues no read", 64'(rd_count), 64'(rc));
        do_op(C_LOAD, 30, 6, '0, "R7 load after disarm");
        do_op(C_LOAD, 38, 1, '0, "R3 evicting load");
        chk(last_wr_line == 30 && last_wr_data == '0, "R7 eviction writes zeros",
            last_wr_data[63:0], 64'd0);

        // R8 clean drop and dirty write-back
        do_op(C_LOAD, 40, 0, '0, "R3 load");
        wc = wr_count;
        do_op(C_LOAD, 48, 0, '0, "R3 load");
        chk(wr_count == wc, "R8 clean line dropped", 64'(wr_count), 64'(wc));
        do_op(C_STORE, 48, 3, 64'h0123_4567_89AB_CDEF, "R2 store");
        do_op(C_LOAD, 48, 3, '0, "R2 read back store");
        do_op(C_LOAD, 40, 7, '0, "R3 evicting load");
        chk(last_wr_line == 48 && last_wr_data == g_data[48], "R8 dirty line written back",
            last_wr_data[255:192], g_data[48][255:192]);

        // Random traffic over sixteen lines
        for (int i = 0; i < 400; i++) begin
            r  = $urandom % 20;
            ln = $urandom % 16;
            if (r < 9)       do_op(C_LOAD,   ln, $urandom % 8, '0, "R3 random load");
            else if (r < 16) do_op(C_STORE,  ln, $urandom % 8, rand_word(), "R2 random store");
            else if (r < 18) do_op(C_ARM,    ln, 0, '0, "R6 random arm");
            else             do_op(C_DISARM, ln, 0, '0, "R7 random disarm");
        end

        // Force every cached random line out, then compare memory
        for (int i = 56; i < 64; i++) do_op(C_LOAD, i, 0, '0, "R3 flush load");
        for (int i = 0; i < 16; i++) begin
            chk(mem_model[i] == g_data[i], "R8 R10 memory matches view",
                mem_model[i][63:0], g_data[i][63:0]);
        end
        chk(!rd_wait && !mem_req_valid, "R10 no memory traffic left",
            {62'd0, rd_wait, mem_req_valid}, 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule